// File: doc/BRIEF.md
# Vector Operand Pre-Processor

This stage sits in front of a vector multiply-accumulate core. It rearranges and conditions a vector of complex operands before they reach the core. Each vector has four lanes, and each lane carries a 16-bit real part and a 16-bit imaginary part.

The operation is not carried in the instruction. A small local store holds sixteen configuration words. An instruction supplies only a 4-bit address into that store, so the run-time control stream stays short. Configuration words are preloaded through a dedicated write port. Any single entry can be rewritten at any time without disturbing the others.

For every lane the stage applies a fixed chain:
1. lane selection (shuffle, or broadcast of one source lane);
2. zero masking;
3. complex conjugation;
4. per-lane negation or absolute value.

The arithmetic saturates, so the most negative 16-bit code never wraps.

Top module: `vec_operand_prep`

## Requirements
- R1: A write on the configuration port stores the word at the given address. A later read of that address returns it. A write to one address leaves every other entry unchanged.
- R2: An operand vector presented with `inValid` and an entry address appears on `outData` with `outValid` high exactly two clock edges later. After reset, `outValid` is 0 and `outData` is all zeros.
- R3: When a configuration write and an operand read hit the same address in the same cycle, the read uses the entry as it was before the write.
- R4: Output lane i takes input lane `shufSel[i]`. When `bcastEn` is 1, every output lane instead takes input lane `bcastSrc`, overriding the shuffle selectors.
- R5: Output lane i is forced to zero in both parts when `zeroMask[i]` is 1. The mask indexes output lanes and is applied after lane selection.
- R6: When `conjEn` is 1, the imaginary part of every lane is negated after masking.
- R7: When `absEn` is 1, both parts of every lane are replaced by their absolute value. Otherwise, lane i has both parts negated when `negMask[i]` is 1. This step follows conjugation.
- R8: Negating −32768 (0x8000), whether by conjugation, negation or absolute value, yields +32767 (0x7FFF).
- R9: The 21-bit configuration word is laid out as follows:
  - `conjEn` at bit 20;
  - `negMask[3:0]` at bits 19:16;
  - `absEn` at bit 15;
  - `zeroMask[3:0]` at bits 14:11;
  - `shufSel[i]` at bits 3+2i+1 : 3+2i;
  - `bcastEn` at bit 2;
  - `bcastSrc` at bits 1:0.

  In `inData` and `outData`, lane i holds its real part at bits 32i+15 : 32i and its imaginary part at bits 32i+31 : 32i+16, both two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 4 | Configuration entry to write |
| cfgWrData | input | 21 | Configuration word |
| inValid | input | 1 | Operand vector valid |
| inAddr | input | 4 | Configuration entry selecting the operation |
| inData | input | 128 | Four complex operand lanes |
| outValid | output | 1 | Result valid |
| outData | output | 128 | Four conditioned complex lanes |

## Verification
Several properties are checked by assertions on every cycle:
- a configuration write lands in the addressed entry;
- results emerge one edge after the decoded control;
- masked lanes come out zero;
- absolute-value results are never negative;
- broadcast with no masking or negation makes all lanes identical.

Other behaviours can only be shown by the bench scenarios against its reference model:
- exact lane ordering under shuffles;
- the order of masking, conjugation and negation;
- saturation of the most negative code;
- the old-entry result of a same-cycle write and read;
- isolation of a partial update from the other entries.

// File: rtl/vpre_pkg.sv
package vpre_pkg;

  localparam int VP_LANES = 4;
  localparam int VP_SELW  = $clog2(VP_LANES);

  typedef logic [VP_SELW-1:0] laneSel_t;

  // Stored configuration word; field order fixes the bit layout.
  typedef struct packed {
    logic                          conjEn;
    logic [VP_LANES-1:0]           negMask;
    logic                          absEn;
    logic [VP_LANES-1:0]           zeroMask;
    laneSel_t [VP_LANES-1:0]       shufSel;
    logic                          bcastEn;
    laneSel_t                      bcastSrc;
  } cfgWord_t;

  localparam int VP_CFGW = $bits(cfgWord_t);

  // Decoded strobes handed from control to datapath.
  typedef struct packed {
    logic                          valid;
    logic                          conjEn;
    logic                          absEn;
    logic                          bcast;
    logic [VP_LANES-1:0]           negMask;
    logic [VP_LANES-1:0]           zeroMask;
    laneSel_t [VP_LANES-1:0]       srcSel;
  } laneCtl_t;

endpackage

// File: rtl/vpre_ctrl.sv
module vpre_ctrl
  import vpre_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWrEn,
  input  logic [AW-1:0]   cfgWrAddr,
  input  cfgWord_t        cfgWrData,
  input  logic            inValid,
  input  logic [AW-1:0]   inAddr,
  output laneCtl_t        ctl
);

  cfgWord_t cfgMem [DEPTH];
  cfgWord_t rdWord;
  laneSel_t [VP_LANES-1:0] srcSelNext;

  // Configuration store: one entry per write, others untouched.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) cfgMem[k] <= '0;
    end else if (cfgWrEn) begin
      cfgMem[cfgWrAddr] <= cfgWrData;
    end
  end

  // Read sees the pre-write contents on a same-cycle collision.
  assign rdWord = cfgMem[inAddr];

  for (genvar i = 0; i < VP_LANES; i++) begin : g_sel
    assign srcSelNext[i] = rdWord.bcastEn ? rdWord.bcastSrc : rdWord.shufSel[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctl <= '0;
    end else begin
      ctl.valid    <= inValid;
      ctl.conjEn   <= rdWord.conjEn;
      ctl.absEn    <= rdWord.absEn;
      ctl.bcast    <= rdWord.bcastEn;
      ctl.negMask  <= rdWord.negMask;
      ctl.zeroMask <= rdWord.zeroMask;
      ctl.srcSel   <= srcSelNext;
    end
  end

  // R1: a written word is held at its address on the next cycle
  a_r1_cfg_store: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgMem[$past(cfgWrAddr)] == $past(cfgWrData)));

endmodule

// File: rtl/vpre_dp.sv
module vpre_dp
  import vpre_pkg::*;
#(
  parameter int DW = 16,
  localparam int LW = 2 * DW,
  localparam int VW = VP_LANES * LW
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [VW-1:0]   inData,
  input  laneCtl_t        ctl,
  output logic            outValid,
  output logic [VW-1:0]   outData
);

  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

  function automatic logic signed [DW-1:0] satNeg(input logic signed [DW-1:0] x);
    return (x == MINV) ? MAXV : -x;
  endfunction

  function automatic logic signed [DW-1:0] satAbs(input logic signed [DW-1:0] x);
    return x[DW-1] ? satNeg(x) : x;
  endfunction

  logic [VW-1:0] dataQ;
  logic signed [DW-1:0] srcRe [VP_LANES];
  logic signed [DW-1:0] srcIm [VP_LANES];
  logic [VW-1:0] resNext;

  // Operand capture, aligned with the configuration read.
  always_ff @(posedge clk) begin
    if (!rstN)        dataQ <= '0;
    else if (inValid) dataQ <= inData;
  end

  for (genvar i = 0; i < VP_LANES; i++) begin : g_split
    assign srcRe[i] = dataQ[i*LW +: DW];
    assign srcIm[i] = dataQ[i*LW+DW +: DW];
  end

  for (genvar i = 0; i < VP_LANES; i++) begin : g_lane
    logic signed [DW-1:0] selRe, selIm, mskRe, mskIm, cjIm, finRe, finIm;

    // Lane selection: shuffle or broadcast (resolved in control).
    assign selRe = srcRe[ctl.srcSel[i]];
    assign selIm = srcIm[ctl.srcSel[i]];

    // Zero masking on the output lane.
    assign mskRe = ctl.zeroMask[i] ? '0 : selRe;
    assign mskIm = ctl.zeroMask[i] ? '0 : selIm;

    // Conjugation.
    assign cjIm = ctl.conjEn ? satNeg(mskIm) : mskIm;

    // Absolute value takes priority over per-lane negation.
    always_comb begin
      if (ctl.absEn) begin
        finRe = satAbs(mskRe);
        finIm = satAbs(cjIm);
      end else if (ctl.negMask[i]) begin
        finRe = satNeg(mskRe);
        finIm = satNeg(cjIm);
      end else begin
        finRe = mskRe;
        finIm = cjIm;
      end
    end

    assign resNext[i*LW +: LW] = {finIm, finRe};

    // R5: a masked lane leaves the stage as zero
    a_r5_masked_zero: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && $past(ctl.zeroMask[i])) |-> (outData[i*LW +: LW] == '0));

    // R7: absolute-value results are never negative
    a_r7_abs_nonneg: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && $past(ctl.absEn)) |->
        (!outData[i*LW+DW-1] && !outData[i*LW+LW-1]));

    // R4: pure broadcast gives identical lanes
    if (i > 0) begin : g_bc
      a_r4_bcast_equal: assert property (@(posedge clk) disable iff (!rstN)
        (outValid && $past(ctl.bcast) && ($past(ctl.negMask) == '0) &&
         ($past(ctl.zeroMask) == '0)) |->
          (outData[i*LW +: LW] == outData[0 +: LW]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctl.valid;
      if (ctl.valid) outData <= resNext;
    end
  end

endmodule

// File: rtl/vec_operand_prep.sv
module vec_operand_prep
  import vpre_pkg::*;
#(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int VW = VP_LANES * 2 * DW
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [AW-1:0]      cfgWrAddr,
  input  logic [VP_CFGW-1:0] cfgWrData,
  input  logic               inValid,
  input  logic [AW-1:0]      inAddr,
  input  logic [VW-1:0]      inData,
  output logic               outValid,
  output logic [VW-1:0]      outData
);

  laneCtl_t ctlBus;

  vpre_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrAddr (cfgWrAddr),
    .cfgWrData (cfgWord_t'(cfgWrData)),
    .inValid   (inValid),
    .inAddr    (inAddr),
    .ctl       (ctlBus)
  );

  vpre_dp #(.DW(DW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inData   (inData),
    .ctl      (ctlBus),
    .outValid (outValid),
    .outData  (outData)
  );

  // R2: a result appears one edge after its decoded control
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(ctlBus.valid));

endmodule

// File: tb/vec_operand_prep_bench.sv
module vec_operand_prep_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [3:0]   cfgWrAddr = '0;
  logic [20:0]  cfgWrData = '0;
  logic         inValid = 1'b0;
  logic [3:0]   inAddr = '0;
  logic [127:0] inData = '0;
  logic         outValid;
  logic [127:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [20:0]  shadow [16];
  logic [127:0] expQ [$];
  string        tagQ [$];

  always #2.5 clk = ~clk;   // 200 MHz

  vec_operand_prep u_vec_operand_prep (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .inValid(inValid), .inAddr(inAddr),
    .inData(inData), .outValid(outValid), .outData(outData)
  );

  function automatic logic [15:0] sneg(input logic [15:0] x);
    return (x == 16'h8000) ? 16'h7FFF : (16'h0000 - x);
  endfunction

  function automatic logic [15:0] sabs(input logic [15:0] x);
    return x[15] ? sneg(x) : x;
  endfunction

  // Reference model built from R4..R9.
  function automatic logic [127:0] model(input logic [20:0] w, input logic [127:0] d);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) begin
      int src;
      logic [15:0] re, im;
      src = w[2] ? int'(w[1:0]) : int'(w[3+2*i +: 2]);
      re = d[32*src +: 16];
      im = d[32*src+16 +: 16];
      if (w[11+i]) begin re = '0; im = '0; end
      if (w[20]) im = sneg(im);
      if (w[15]) begin re = sabs(re); im = sabs(im); end
      else if (w[16+i]) begin re = sneg(re); im = sneg(im); end
      r[32*i +: 32] = {im, re};
    end
    return r;
  endfunction

  function automatic logic [20:0] mkCfg(input logic conj, input logic [3:0] neg,
      input logic absE, input logic [3:0] zm, input logic [1:0] s3, input logic [1:0] s2,
      input logic [1:0] s1, input logic [1:0] s0, input logic bc, input logic [1:0] bs);
    return {conj, neg, absE, zm, s3, s2, s1, s0, bc, bs};
  endfunction

  function automatic logic [127:0] vec4(input logic [15:0] r0, input logic [15:0] i0,
      input logic [15:0] r1, input logic [15:0] i1, input logic [15:0] r2,
      input logic [15:0] i2, input logic [15:0] r3, input logic [15:0] i3);
    return {i3, r3, i2, r2, i1, r1, i0, r0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrCfg(input logic [3:0] a, input logic [20:0] w);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = w;
    @(negedge clk);
    cfgWrEn = 1'b0;
    shadow[a] = w;
  endtask

  // Issue one operand; inputs stay until the next call or idle.
  task automatic issue(input logic [3:0] a, input logic [127:0] d, input string tag);
    inValid = 1'b1; inAddr = a; inData = d;
    expQ.push_back(model(shadow[a], d));
    tagQ.push_back(tag);
    @(negedge clk);
  endtask

  task automatic issueWr(input logic [3:0] a, input logic [127:0] d,
                         input logic [20:0] w, input string tag);
    inValid = 1'b1; inAddr = a; inData = d;
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = w;
    expQ.push_back(model(shadow[a], d));
    tagQ.push_back(tag);
    @(negedge clk);
    cfgWrEn = 1'b0;
    shadow[a] = w;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected output", outData, '0);
      end else begin
        logic [127:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(outData === e, t, outData, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] dA, dB, dM;
    logic [31:0] lf;
    for (int k = 0; k < 16; k++) shadow[k] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2: reset state
    chk(outValid === 1'b0 && outData === '0, "R2 reset state",
        {127'b0, outValid}, '0);

    dA = vec4(16'd100, 16'd200, 16'hFF38, 16'd7, 16'd1234, 16'hFFFE, 16'h7FFF, 16'h0003);
    dB = vec4(16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0055, 16'h0066, 16'h0077, 16'h0088);
    dM = vec4(16'h8000, 16'h8000, 16'h8000, 16'h0001, 16'h7FFF, 16'h8000, 16'h0005, 16'hFFFB);

    // R9/R4: identity shuffle, then reverse, then broadcast
    wrCfg(4'd0, mkCfg(0, 4'h0, 0, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));
    wrCfg(4'd1, mkCfg(0, 4'h0, 0, 4'h0, 2'd0, 2'd1, 2'd2, 2'd3, 0, 2'd0));
    wrCfg(4'd2, mkCfg(0, 4'h0, 0, 4'h0, 2'd0, 2'd1, 2'd2, 2'd3, 1, 2'd2));
    // R5: mask lanes 1 and 3 after a rotate
    wrCfg(4'd3, mkCfg(0, 4'h0, 0, 4'hA, 2'd2, 2'd1, 2'd0, 2'd3, 0, 2'd0));
    // R6: conjugate
    wrCfg(4'd4, mkCfg(1, 4'h0, 0, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));
    // R7: negate lanes 0 and 2; abs with negate mask also set
    wrCfg(4'd5, mkCfg(0, 4'h5, 0, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));
    wrCfg(4'd6, mkCfg(0, 4'hF, 1, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));
    // R7/R6 ordering: conj then negate all
    wrCfg(4'd7, mkCfg(1, 4'hF, 0, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));
    // R8: conj plus abs
    wrCfg(4'd8, mkCfg(1, 4'h0, 1, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0));

    issue(4'd0, dA, "R9 identity layout");
    issue(4'd1, dA, "R4 reverse shuffle");
    issue(4'd2, dA, "R4 broadcast lane 2");
    issue(4'd3, dA, "R5 mask after shuffle");
    issue(4'd4, dA, "R6 conjugate");
    issue(4'd5, dA, "R7 per-lane negate");
    issue(4'd6, dA, "R7 abs over negate");
    issue(4'd7, dA, "R7 conj then negate");
    issue(4'd5, dM, "R8 negate min value");
    issue(4'd6, dM, "R8 abs min value");
    issue(4'd4, dM, "R8 conj min value");
    issue(4'd8, dM, "R8 conj plus abs");
    idle(4);

    // R3: same-cycle write and read of entry 1 uses the old word
    issueWr(4'd1, dB, mkCfg(1, 4'hF, 0, 4'h0, 2'd3, 2'd2, 2'd1, 2'd0, 0, 2'd0),
            "R3 old entry on collision");
    issue(4'd1, dB, "R3 new entry afterwards");
    idle(4);

    // R1: partial update of entry 9 leaves entries 0 and 2 intact
    wrCfg(4'd9, mkCfg(0, 4'h3, 0, 4'h4, 2'd1, 2'd1, 2'd0, 2'd0, 0, 2'd0));
    issue(4'd9, dB, "R1 written entry");
    issue(4'd0, dB, "R1 entry 0 untouched");
    issue(4'd2, dB, "R1 entry 2 untouched");
    issue(4'd15, dB, "R1 unwritten entry is zero");
    idle(4);

    // R2: back-to-back stream over all configured entries
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 120; n++) begin
      logic [127:0] d;
      for (int q = 0; q < 4; q++) begin
        lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
        d[32*q +: 32] = lf;
      end
      issue(4'(n % 10), d, "R2 streaming");
    end
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R2 missing outputs: actual %0d pending expected 0", expQ.size());
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule